// File: doc/BRIEF.md
# Round-Robin MSI Request Forwarder

Seven requesters share one path for raising message-signalled interrupts. Each requester owns one request slot in a small register file. It posts a request by writing its vector number plus one into its slot, so a slot that holds zero is idle. After software sets the run bit, the forwarder scans the slots in ascending order. For every pending slot it raises the interrupt by issuing three single-beat writes to a GPIO-style bridge peripheral: the vector, a trigger high and a trigger low. It then stalls until the driver's acknowledge line goes high.

Once acknowledged, the forwarder clears the slot. It does this with a bus write to the slot's mirror address and also in the register file itself. It then clears the acknowledge peripheral with one more write and moves to the next slot. The register port also holds three base-address settings: the MSI peripheral, the acknowledge peripheral and the slot mirror. It also holds a control word with a run bit and an auto-restart bit.

Top module: `msi_fwd`

## Requirements
- R1: After reset, status reads 0 (idle), bus_valid is low, and every register (slots, both bases, slot offset, control) reads zero.
- R2: Register word indices are 0..6 for the slots, 8 for the MSI peripheral base, 9 for the acknowledge peripheral base, 10 for the slot mirror offset, and 11 for control (bit 0 run, bit 1 auto-restart). A written value reads back unchanged while the block is idle.
- R3: For a slot holding a non-zero value v, the block writes v-1 to MSI base + 0x8, then 1 to MSI base + 0x0, then 0 to MSI base + 0x0, in that order.
- R4: Slots are examined one at a time in ascending index order 0..6. A slot holding zero causes no bus write.
- R5: After the trigger-low write, status reads 2 and no bus write is issued until the acknowledge input, passed through two flip-flops, is seen high. The first clear write starts on the third rising edge after acknowledge rises.
- R6: After acknowledge, the block writes 0 to slot offset + 4 × index, after which the slot reads 0. It then writes 0 to acknowledge base + 0x0.
- R7: A bus write keeps bus_valid high with bus_addr and bus_wdata stable until bus_ready is sampled high, and the next write starts only after that.
- R8: After slot 6, the scan restarts at slot 0 if auto-restart is set. Otherwise the block returns to idle and the run bit reads 0.
- R9: If a requester writes a slot in the same cycle that the block's slot clear completes, the requester's value is kept.
- R10: status encodes 0 for idle, 1 for scanning or issuing writes, and 2 for waiting on acknowledge. The value 3 never appears, and bus_valid is low whenever status is 0 or 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| bus_addr | output | 32 | Master write byte address |
| bus_wdata | output | 32 | Master write data |
| bus_valid | output | 1 | Master write request |
| bus_ready | input | 1 | Peripheral accepts the write |
| ack_in | input | 1 | Driver acknowledge, asynchronous |
| status | output | 2 | 0 idle, 1 scanning, 2 waiting for acknowledge |

## Verification
A requester's register write and the forwarder's own slot clear can land on the same slot in the same cycle. The bench provokes this from its bus model. At the exact negedge where it grants the clear write for slot 2, the model also drives a register write of a fresh value into slot 2, so both take effect at the same rising edge. After the pass ends, the bench reads slot 2 back and judges the collision correct only if it holds the requester's value, not zero.

// File: rtl/msi_fwd_pkg.sv
package msi_fwd_pkg;

    localparam int BUS_W = 32;

    // byte offsets of the two data channels inside a GPIO-style peripheral
    localparam logic [BUS_W-1:0] CH1_OFF = 32'h0;
    localparam logic [BUS_W-1:0] CH2_OFF = 32'h8;

    // register word indices above the slot range
    localparam int REG_MSI_BASE = 8;
    localparam int REG_ACK_BASE = 9;
    localparam int REG_SLOT_OFF = 10;
    localparam int REG_CTRL     = 11;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_VEC,
        S_TRIG_HI,
        S_TRIG_LO,
        S_WAIT,
        S_CLR_SLOT,
        S_CLR_ACK
    } seq_state_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SCAN    = 2'd1,
        ST_ACKWAIT = 2'd2
    } status_e;

    typedef struct packed {
        logic             valid;
        logic [BUS_W-1:0] addr;
        logic [BUS_W-1:0] data;
    } bus_wr_t;

    function automatic status_e state_status(seq_state_e s);
        case (s)
            S_IDLE:  return ST_IDLE;
            S_WAIT:  return ST_ACKWAIT;
            default: return ST_SCAN;
        endcase
    endfunction

endpackage

// File: rtl/msi_fwd_sync.sv
module msi_fwd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/msi_fwd_regs.sv
module msi_fwd_regs
    import msi_fwd_pkg::*;
#(
    parameter int NUM_SLOTS = 7,
    parameter int REG_AW    = 4,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             reg_wr,
    input  logic [REG_AW-1:0]                reg_addr,
    input  logic [BUS_W-1:0]                 reg_wdata,
    output logic [BUS_W-1:0]                 reg_rdata,
    input  logic                             clr_en,
    input  logic [IDX_W-1:0]                 clr_idx,
    input  logic                             run_clr,
    output logic [NUM_SLOTS-1:0][BUS_W-1:0]  slots,
    output logic [BUS_W-1:0]                 msi_base,
    output logic [BUS_W-1:0]                 ack_base,
    output logic [BUS_W-1:0]                 slot_off,
    output logic                             run,
    output logic                             auto_rs
);
    // a requester's write takes precedence over the self-clear
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slots[g] <= '0;
            else if (reg_wr && reg_addr == REG_AW'(g))
                slots[g] <= reg_wdata;
            else if (clr_en && clr_idx == IDX_W'(g))
                slots[g] <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msi_base <= '0;
            ack_base <= '0;
            slot_off <= '0;
            run      <= 1'b0;
            auto_rs  <= 1'b0;
        end else begin
            if (run_clr) run <= 1'b0;
            if (reg_wr) begin
                case (reg_addr)
                    REG_AW'(REG_MSI_BASE): msi_base <= reg_wdata;
                    REG_AW'(REG_ACK_BASE): ack_base <= reg_wdata;
                    REG_AW'(REG_SLOT_OFF): slot_off <= reg_wdata;
                    REG_AW'(REG_CTRL): begin
                        run     <= reg_wdata[0];
                        auto_rs <= reg_wdata[1];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (reg_addr == REG_AW'(i)) reg_rdata = slots[i];
        case (reg_addr)
            REG_AW'(REG_MSI_BASE): reg_rdata = msi_base;
            REG_AW'(REG_ACK_BASE): reg_rdata = ack_base;
            REG_AW'(REG_SLOT_OFF): reg_rdata = slot_off;
            REG_AW'(REG_CTRL):     reg_rdata = {30'd0, auto_rs, run};
            default: ;
        endcase
    end
endmodule

// File: rtl/msi_fwd_seq.sv
module msi_fwd_seq
    import msi_fwd_pkg::*;
#(
    parameter int NUM_SLOTS = 7,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_SLOTS-1:0][BUS_W-1:0]  slots,
    input  logic [BUS_W-1:0]                 msi_base,
    input  logic [BUS_W-1:0]                 ack_base,
    input  logic [BUS_W-1:0]                 slot_off,
    input  logic                             run,
    input  logic                             auto_rs,
    input  logic                             ack_s,
    input  logic                             bus_ready,
    output bus_wr_t                          wr,
    output logic                             clr_en,
    output logic [IDX_W-1:0]                 clr_idx,
    output logic                             run_clr,
    output status_e                          status
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

    seq_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [BUS_W-1:0] vec;
    logic [BUS_W-1:0] slot_cur;
    logic             last, step;

    assign slot_cur = slots[idx];
    assign last     = (idx == LAST);
    assign step     = (state == S_CHECK && slot_cur == '0) ||
                      (state == S_CLR_ACK && bus_ready);
    assign run_clr  = step && last && !auto_rs;
    assign clr_en   = (state == S_CLR_SLOT) && bus_ready;
    assign clr_idx  = idx;
    assign status   = state_status(state);

    always_comb begin
        wr = '0;
        case (state)
            S_VEC:      wr = '{valid: 1'b1, addr: msi_base + CH2_OFF, data: vec};
            S_TRIG_HI:  wr = '{valid: 1'b1, addr: msi_base + CH1_OFF, data: 32'd1};
            S_TRIG_LO:  wr = '{valid: 1'b1, addr: msi_base + CH1_OFF, data: 32'd0};
            S_CLR_SLOT: wr = '{valid: 1'b1, addr: slot_off + (BUS_W'(idx) << 2), data: 32'd0};
            S_CLR_ACK:  wr = '{valid: 1'b1, addr: ack_base + CH1_OFF, data: 32'd0};
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            idx   <= '0;
            vec   <= '0;
        end else begin
            case (state)
                S_IDLE:     if (run) begin idx <= '0; state <= S_CHECK; end
                S_CHECK:    if (slot_cur != '0) begin vec <= slot_cur - 1; state <= S_VEC; end
                S_VEC:      if (bus_ready) state <= S_TRIG_HI;
                S_TRIG_HI:  if (bus_ready) state <= S_TRIG_LO;
                S_TRIG_LO:  if (bus_ready) state <= S_WAIT;
                S_WAIT:     if (ack_s) state <= S_CLR_SLOT;
                S_CLR_SLOT: if (bus_ready) state <= S_CLR_ACK;
                S_CLR_ACK:  ;
                default:    state <= S_IDLE;
            endcase
            if (step) begin
                if (!last) begin
                    idx   <= idx + 1'b1;
                    state <= S_CHECK;
                end else begin
                    idx   <= '0;
                    state <= auto_rs ? S_CHECK : S_IDLE;
                end
            end
        end
    end
endmodule

// File: rtl/msi_fwd.sv
module msi_fwd
    import msi_fwd_pkg::*;
#(
    parameter int NUM_SLOTS = 7,
    parameter int REG_AW    = 4,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [31:0]       bus_addr,
    output logic [31:0]       bus_wdata,
    output logic              bus_valid,
    input  logic              bus_ready,
    input  logic              ack_in,
    output logic [1:0]        status
);
    localparam int IDX_W = $clog2(NUM_SLOTS);

    logic [NUM_SLOTS-1:0][BUS_W-1:0] slots;
    logic [BUS_W-1:0] msi_base, ack_base, slot_off;
    logic             run, auto_rs, ack_s, clr_en, run_clr;
    logic [IDX_W-1:0] clr_idx;
    bus_wr_t          wr;
    status_e          st;

    msi_fwd_regs #(.NUM_SLOTS(NUM_SLOTS), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clr_en(clr_en),
        .clr_idx(clr_idx), .run_clr(run_clr), .slots(slots),
        .msi_base(msi_base), .ack_base(ack_base), .slot_off(slot_off),
        .run(run), .auto_rs(auto_rs)
    );

    msi_fwd_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst(rst), .d(ack_in), .q(ack_s)
    );

    msi_fwd_seq #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
        .clk(clk), .rst(rst), .slots(slots), .msi_base(msi_base),
        .ack_base(ack_base), .slot_off(slot_off), .run(run),
        .auto_rs(auto_rs), .ack_s(ack_s), .bus_ready(bus_ready), .wr(wr),
        .clr_en(clr_en), .clr_idx(clr_idx), .run_clr(run_clr), .status(st)
    );

    assign bus_valid = wr.valid;
    assign bus_addr  = wr.addr;
    assign bus_wdata = wr.data;
    assign status    = st;
endmodule

// File: rtl/msi_fwd_chk.sv
module msi_fwd_chk #(
    parameter int NUM_SLOTS = 7,
    parameter int REG_AW    = 4,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            reg_wr,
    input logic [REG_AW-1:0]               reg_addr,
    input logic [31:0]                     reg_wdata,
    input logic [31:0]                     bus_addr,
    input logic [31:0]                     bus_wdata,
    input logic                            bus_valid,
    input logic                            bus_ready,
    input logic [1:0]                      status,
    input logic [NUM_SLOTS-1:0][31:0]      slots,
    input logic                            clr_en,
    input logic [IDX_W-1:0]                clr_idx
);
    // R7
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_wdata));

    // R5
    ack_wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        status == 2'd2 |-> !bus_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        status == 2'd0 |-> !bus_valid);

    // R10
    status_legal_chk: assert property (@(posedge clk) disable iff (rst)
        status != 2'd3);

    // R6
    slot_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_en && !(reg_wr && reg_addr == REG_AW'(clr_idx)) |=> slots[$past(clr_idx)] == '0);

    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_en && reg_wr && reg_addr == REG_AW'(clr_idx) |=> slots[$past(clr_idx)] == $past(reg_wdata));
endmodule

bind msi_fwd msi_fwd_chk #(.NUM_SLOTS(NUM_SLOTS), .REG_AW(REG_AW)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .status(status),
    .slots(slots), .clr_en(clr_en), .clr_idx(clr_idx)
);

// File: tb/tb_msi_fwd.sv
module tb_msi_fwd;
    localparam int NS = 7;
    localparam logic [31:0] MSI_B = 32'h4000_0000;
    localparam logic [31:0] ACK_B = 32'h4001_0000;
    localparam logic [31:0] OFF_B = 32'h8000_0100;

    // slot pattern (nibble i = value posted to slot i) and bus stall count
    localparam logic [27:0] PAT   [6] = '{28'h0000000, 28'h0000001, 28'h7000000,
                                          28'h0604020, 28'h7654321, 28'h0050300};
    localparam int          STALL [6] = '{0, 0, 1, 2, 0, 3};

    logic        clk = 0, rst = 1;
    logic        reg_wr = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_valid, bus_ready = 0, ack_in = 0;
    logic [1:0]  status;

    int errors = 0, checks = 0;
    logic [31:0] log_a [0:63];
    logic [31:0] log_d [0:63];
    int  log_n = 0;
    int  stall = 0;
    bit  ack_auto = 1;
    bit  coll_en = 0;
    int  wait_writes = 0;
    logic [31:0] exp_a [0:63];
    logic [31:0] exp_d [0:63];
    int  exp_n;

    msi_fwd dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .ack_in(ack_in), .status(status)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        @(negedge clk); @(negedge clk);
        for (int i = 0; i < 5000 && status != 2'd0; i++) @(negedge clk);
    endtask

    // bus slave and acknowledge responder
    initial begin
        int wcnt = 0, adly = 0;
        bit coll_on = 0;
        forever begin
            @(negedge clk);
            if (coll_on) begin reg_wr = 0; coll_on = 0; end
            if (status == 2'd2 && bus_valid) wait_writes++;
            if (bus_valid) begin
                if (wcnt >= stall) begin
                    bus_ready = 1; wcnt = 0;
                    if (log_n < 64) begin log_a[log_n] = bus_addr; log_d[log_n] = bus_wdata; end
                    log_n++;
                    if (bus_addr == ACK_B) ack_in = 0;
                    if (coll_en && bus_addr == OFF_B + 32'd8) begin
                        reg_wr = 1; reg_addr = 4'd2; reg_wdata = 32'd5; coll_on = 1;
                    end
                end else begin
                    bus_ready = 0; wcnt++;
                end
            end else begin
                bus_ready = 0; wcnt = 0;
            end
            if (ack_auto && status == 2'd2 && !ack_in) begin
                adly++;
                if (adly >= 3) begin ack_in = 1; adly = 0; end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    task automatic add_exp(input logic [31:0] a, input logic [31:0] d);
        exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++;
    endtask

    task automatic add_slot(input int i, input logic [31:0] v);
        add_exp(MSI_B + 32'h8, v - 1);
        add_exp(MSI_B, 32'd1);
        add_exp(MSI_B, 32'd0);
        add_exp(OFF_B + 32'(i * 4), 32'd0);
        add_exp(ACK_B, 32'd0);
    endtask

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        check(status == 2'd0, "R1 status", 32'(status), 0);
        check(!bus_valid, "R1 bus_valid", 32'(bus_valid), 0);
        for (int a = 0; a < 12; a++) begin
            if (a == 7) continue;
            rd_reg(4'(a), rv);
            check(rv == 0, "R1 register", rv, 0);
        end

        // R2: configuration readback
        wr_reg(4'd8, MSI_B); wr_reg(4'd9, ACK_B); wr_reg(4'd10, OFF_B);
        wr_reg(4'd11, 32'd2);
        rd_reg(4'd8, rv);  check(rv == MSI_B, "R2 msi base", rv, MSI_B);
        rd_reg(4'd9, rv);  check(rv == ACK_B, "R2 ack base", rv, ACK_B);
        rd_reg(4'd10, rv); check(rv == OFF_B, "R2 slot offset", rv, OFF_B);
        rd_reg(4'd11, rv); check(rv == 32'd2, "R2 control", rv, 2);
        wr_reg(4'd3, 32'h55); rd_reg(4'd3, rv); check(rv == 32'h55, "R2 slot", rv, 32'h55);
        wr_reg(4'd3, 0); wr_reg(4'd11, 0);

        // table of scan passes: R3 R4 R6 R7 R8
        for (int e = 0; e < 6; e++) begin
            stall = STALL[e];
            exp_n = 0;
            for (int i = 0; i < NS; i++) begin
                logic [31:0] v = 32'(PAT[e][i*4 +: 4]);
                if (v != 0) begin wr_reg(4'(i), v); add_slot(i, v); end
            end
            log_n = 0; wait_writes = 0;
            wr_reg(4'd11, 32'd1);
            wait_idle();
            check(log_n == exp_n, "R4 write count", 32'(log_n), 32'(exp_n));
            for (int k = 0; k < exp_n && k < log_n; k++)
                check(log_a[k] == exp_a[k] && log_d[k] == exp_d[k],
                      (k % 5 < 3) ? "R3/R7 trigger write" : "R6/R7 clear write",
                      log_a[k] ^ log_d[k], exp_a[k] ^ exp_d[k]);
            check(wait_writes == 0, "R5 write while waiting", 32'(wait_writes), 0);
            for (int i = 0; i < NS; i++) begin
                rd_reg(4'(i), rv); check(rv == 0, "R6 slot cleared", rv, 0);
            end
            rd_reg(4'd11, rv); check(rv == 0, "R8 run bit self-clears", rv, 0);
        end
        stall = 0;

        // R5: blocking wait and two-stage synchronizer latency
        ack_auto = 0;
        wr_reg(4'd3, 32'd4);
        log_n = 0;
        wr_reg(4'd11, 32'd1);
        for (int i = 0; i < 200 && status != 2'd2; i++) @(negedge clk);
        repeat (10) @(negedge clk);
        check(status == 2'd2, "R5 still waiting", 32'(status), 2);
        check(log_n == 3, "R5 no writes while waiting", 32'(log_n), 3);
        ack_in = 1;
        @(negedge clk); check(status == 2'd2, "R5 sync edge 1", 32'(status), 2);
        @(negedge clk); check(status == 2'd2, "R5 sync edge 2", 32'(status), 2);
        @(negedge clk); check(status == 2'd1 && bus_valid && bus_addr == OFF_B + 32'd12,
                              "R5 clear after sync", bus_addr, OFF_B + 32'd12);
        ack_auto = 1;
        wait_idle();
        check(status == 2'd0, "R10 idle after pass", 32'(status), 0);

        // R8: auto-restart returns to slot 0
        wr_reg(4'd5, 32'd6);
        log_n = 0;
        wr_reg(4'd11, 32'd3);
        for (int i = 0; i < 500 && log_n < 5; i++) @(negedge clk);
        wr_reg(4'd1, 32'd2);
        for (int i = 0; i < 500 && log_n < 10; i++) @(negedge clk);
        check(log_n >= 10 && log_d[5] == 32'd1 && log_a[5] == MSI_B + 32'h8,
              "R8 restart vector", log_d[5], 32'd1);
        check(log_a[8] == OFF_B + 32'd4, "R8 restart clears slot 1", log_a[8], OFF_B + 32'd4);
        wr_reg(4'd11, 32'd0);
        wait_idle();
        check(status == 2'd0, "R8 stops when auto-restart off", 32'(status), 0);

        // R9: requester write collides with self-clear of slot 2
        wr_reg(4'd2, 32'd3);
        coll_en = 1;
        wr_reg(4'd11, 32'd1);
        wait_idle();
        coll_en = 0;
        rd_reg(4'd2, rv);
        check(rv == 32'd5, "R9 requester write kept", rv, 5);
        wr_reg(4'd2, 0);

        // R1: reset in mid-flight
        wr_reg(4'd4, 32'd5);
        wr_reg(4'd11, 32'd1);
        repeat (3) @(negedge clk);
        rst = 1; @(negedge clk); rst = 0;
        #1;
        check(status == 2'd0 && !bus_valid, "R1 reset mid-pass", 32'(status), 0);
        rd_reg(4'd4, rv); check(rv == 0, "R1 slot after reset", rv, 0);

        finish_run();
    end
endmodule